// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM and turns a write request into correctly timed pin activity. A request gives a start address and a byte count through a valid/ready handshake. The payload bytes then arrive one at a time on a second valid/ready stream. For each byte the sequencer drives address and data and pulls chip-enable low. It then gives a write-enable low pulse and holds the bus for a short hold time. All of these times are clock-cycle counts derived from the clock period. Output-enable stays high throughout, because the block never reads.

Bytes that share a page are loaded back to back, so the gap between write pulses stays far below the device's load window. When a byte is the last of the request, or sits on the final address of a page, the sequencer releases the bus and waits out the programming time. It then continues with the rest of the request, so a request that crosses a page boundary becomes several page writes. After the last programming wait it gives a one-cycle done pulse and returns to idle. After reset it refuses all requests for a write-inhibit period.

The controller walks through these states: INHIBIT (power-up hold-off), IDLE (request accepted), FETCH (take one byte), SETUP (bus driven, write-enable high), WE_LOW (write pulse), WE_HIGH (hold after the pulse), PROG (programming wait) and DONE (completion pulse). The transitions are:
- INHIBIT→IDLE when the inhibit count runs out.
- IDLE→FETCH when a request is accepted.
- FETCH→SETUP when a byte is taken.
- SETUP→WE_LOW after one cycle.
- WE_LOW→WE_HIGH after the pulse count.
- WE_HIGH→FETCH after the hold count when the byte was mid-page, or WE_HIGH→PROG when it was the last byte of the request or of a page.
- PROG→FETCH when bytes remain, or PROG→DONE when none remain.
- DONE→IDLE after one cycle.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset is released, `req_ready` stays low and `ee_we_n` stays high for exactly `INHIBIT_CYC` rising clock edges. `req_ready` goes high only after those edges.
- R2: `req_ready` is high only while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_len` holds the byte count minus one. `req_ready` stays low from acceptance until the done pulse.
- R3: Byte i of a request is written at address `req_addr + i`, in stream order, with the i-th byte taken from `wr_data`.
- R4: Each write-enable low pulse lasts exactly `WE_LOW_CYC` cycles. Chip-enable is low throughout the pulse, and address and data do not change during it.
- R5: Address and data are on the pins, with chip-enable low, one cycle before write-enable falls. They stay unchanged, with chip-enable still low, for `WE_HIGH_CYC` cycles after write-enable rises.
- R6: Between two bytes of the same page, write-enable stays high for exactly `WE_HIGH_CYC + 2` cycles.
- R7: A page ends at a byte whose address has all low `log2(PAGE_BYTES)` bits set, or at the last byte of the request. After that byte, write-enable stays high for at least `WE_HIGH_CYC + PROG_CYC` cycles before the next write pulse.
- R8: `done` is high for exactly one cycle, `WE_HIGH_CYC + PROG_CYC + 1` cycles after the last write-enable rise of the request. `req_ready` is high in the following cycle.
- R9: `ee_oe_n` is high in every cycle.
- R10: `ee_ce_n` is low exactly in the cycles where `ee_data_oe` is high, and high in every other cycle, including the programming wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | LEN_W | Number of bytes minus one |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Controller takes a payload byte this cycle |
| wr_data | input | 8 | Payload byte |
| done | output | 1 | One-cycle pulse after the last programming wait |
| ee_ce_n | output | 1 | Device chip-enable, active low |
| ee_we_n | output | 1 | Device write-enable, active low |
| ee_oe_n | output | 1 | Device output-enable, active low (held high) |
| ee_addr | output | ADDR_W | Device address pins |
| ee_data | output | 8 | Device data pins |
| ee_data_oe | output | 1 | Drive enable for the data pins |

## Verification
A wrong address counter or a byte taken in the wrong cycle shows up as a wrong address or data value at the very next write-enable rise. A wrong state or timer reload shows as a write pulse or high gap that is one or more cycles too long or too short. The bench measures both directly from the pin edges. A page-end decision that is wrong in either direction changes the gap before the following pulse by about `PROG_CYC` cycles, and a bad remaining-byte count moves or removes the done pulse. The bench sees each of these within one byte load or one programming wait. An inhibit count that is wrong by one shows as `req_ready` rising one edge early or late.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

    typedef enum logic [2:0] {
        ST_INHIBIT,
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_WE_LOW,
        ST_WE_HIGH,
        ST_PROG,
        ST_DONE
    } ewr_state_e;

endpackage

// File: rtl/ewr_timer.sv
module ewr_timer #(
    parameter int unsigned TW      = 8,
    parameter logic [TW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R1
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt) == '0 && $past(!load)) |-> (cnt == '0));

endmodule

// File: rtl/ewr_addr_track.sv
module ewr_addr_track #(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned CNT_W      = 9,
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_byte,
    output logic              page_end,
    output logic              empty
);

    localparam int unsigned PW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
        end else if (start) begin
            cur_addr  <= start_addr;
            remaining <= start_count;
        end else if (step) begin
            cur_addr  <= cur_addr + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign last_byte = (remaining == CNT_W'(1));
    assign empty     = (remaining == '0);

    generate
        if (PAGE_BYTES > 1) begin : g_paged
            assign page_end = &cur_addr[PW-1:0];
        end else begin : g_single
            assign page_end = 1'b1;
        end
    endgenerate

    // R3
    step_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !empty);

    // R3
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (cur_addr == $past(cur_addr) + 1'b1));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import ewr_pkg::*;
#(
    parameter int unsigned CLK_PS      = 4000,
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned PAGE_BYTES  = 32,
    parameter int unsigned WE_LOW_CYC  = (110000 + CLK_PS - 1) / CLK_PS,
    parameter int unsigned WE_HIGH_CYC = (20000 + CLK_PS - 1) / CLK_PS,
    parameter int unsigned PROG_CYC    = int'((64'd5000000000 + 64'(CLK_PS) - 64'd1) / 64'(CLK_PS)),
    parameter int unsigned INHIBIT_CYC = int'((64'd10000000000 + 64'(CLK_PS) - 64'd1) / 64'(CLK_PS))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              done,
    output logic              ee_ce_n,
    output logic              ee_we_n,
    output logic              ee_oe_n,
    output logic [ADDR_W-1:0] ee_addr,
    output logic [7:0]        ee_data,
    output logic              ee_data_oe
);

    localparam int unsigned CNT_W = LEN_W + 1;
    localparam int unsigned MAX_A = (INHIBIT_CYC > PROG_CYC) ? INHIBIT_CYC : PROG_CYC;
    localparam int unsigned MAX_B = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW    = $clog2(MAX_C + 1);

    ewr_state_e state, state_nx;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          trk_start;
    logic          trk_step;
    logic          last_byte;
    logic          page_end;
    logic          trk_empty;
    logic [7:0]    data_q;
    logic          drive;

    ewr_timer #(
        .TW      (TW),
        .RST_VAL (TW'(INHIBIT_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    ewr_addr_track #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (trk_start),
        .start_addr  (req_addr),
        .start_count (CNT_W'(req_len) + 1'b1),
        .step        (trk_step),
        .cur_addr    (ee_addr),
        .last_byte   (last_byte),
        .page_end    (page_end),
        .empty       (trk_empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INHIBIT;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_valid && wr_ready) begin
            data_q <= wr_data;
        end
    end

    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        trk_start = 1'b0;
        trk_step  = 1'b0;
        unique case (state)
            ST_INHIBIT: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    trk_start = 1'b1;
                    state_nx  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (wr_valid) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(WE_LOW_CYC - 1);
                state_nx = ST_WE_LOW;
            end
            ST_WE_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WE_HIGH_CYC - 1);
                    state_nx = ST_WE_HIGH;
                end
            end
            ST_WE_HIGH: begin
                if (tmr_done) begin
                    trk_step = 1'b1;
                    if (last_byte || page_end) begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(PROG_CYC - 1);
                        state_nx = ST_PROG;
                    end else begin
                        state_nx = ST_FETCH;
                    end
                end
            end
            ST_PROG: begin
                if (tmr_done) state_nx = trk_empty ? ST_DONE : ST_FETCH;
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_INHIBIT;
        endcase
    end

    always_comb begin
        drive      = (state == ST_SETUP) || (state == ST_WE_LOW) || (state == ST_WE_HIGH);
        req_ready  = (state == ST_IDLE);
        wr_ready   = (state == ST_FETCH);
        done       = (state == ST_DONE);
        ee_ce_n    = !drive;
        ee_we_n    = (state != ST_WE_LOW);
        ee_oe_n    = 1'b1;
        ee_data_oe = drive;
        ee_data    = data_q;
    end

    logic [15:0] we_low_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_len <= '0;
        end else if (!ee_we_n) begin
            we_low_len <= we_low_len + 1'b1;
        end else begin
            we_low_len <= '0;
        end
    end

    // R4
    we_fall_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_we_n) |-> !ee_ce_n);

    // R4
    we_low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_data)));

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_we_n) |-> (we_low_len == 16'(WE_LOW_CYC)));

    // R5
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_we_n) |=> ($stable(ee_addr) && !ee_ce_n));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;

    localparam int unsigned ADDR_W  = 13;
    localparam int unsigned LEN_W   = 8;
    localparam int unsigned PB      = 8;
    localparam int unsigned WE_LOW  = 4;
    localparam int unsigned WE_HIGH = 3;
    localparam int unsigned PROG    = 20;
    localparam int unsigned INHIB   = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [7:0]        wr_data = '0;
    logic              done;
    logic              ee_ce_n, ee_we_n, ee_oe_n, ee_data_oe;
    logic [ADDR_W-1:0] ee_addr;
    logic [7:0]        ee_data;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned done_cnt = 0;
    bit          busy = 1'b0;
    bit          finished = 1'b0;

    logic [ADDR_W+8:0] exp_q[$];

    always #2 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .PAGE_BYTES  (PB),
        .WE_LOW_CYC  (WE_LOW),
        .WE_HIGH_CYC (WE_HIGH),
        .PROG_CYC    (PROG),
        .INHIBIT_CYC (INHIB)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_data    (wr_data),
        .done       (done),
        .ee_ce_n    (ee_ce_n),
        .ee_we_n    (ee_we_n),
        .ee_oe_n    (ee_oe_n),
        .ee_addr    (ee_addr),
        .ee_data    (ee_data),
        .ee_data_oe (ee_data_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return 8'(a * 7 + 13);
    endfunction

    task automatic run_req(input logic [ADDR_W-1:0] a, input int n);
        int unsigned d0;
        for (int i = 0; i < n; i++) begin
            logic [ADDR_W-1:0] ad;
            logic              lst;
            ad  = a + ADDR_W'(i);
            lst = (i == n - 1) || ((ad % PB) == PB - 1);
            exp_q.push_back({lst, ad, pat(ad)});
        end
        d0 = done_cnt;
        @(negedge clk);
        req_addr  = a;
        req_len   = LEN_W'(n - 1);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        busy      = 1'b1;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = pat(a + ADDR_W'(i));
            @(negedge clk);
            while (!wr_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
        wr_valid = 1'b0;
        while (done_cnt == d0) @(negedge clk);
    endtask

    // scoreboard monitor
    logic              prev_we = 1'b1;
    logic              prev_ce = 1'b1;
    logic              prev_done = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [7:0]        prev_data = '0;
    logic [ADDR_W-1:0] cap_addr = '0;
    logic [7:0]        cap_data = '0;
    int unsigned       low_cnt = 0;
    int unsigned       high_cnt = 0;
    int unsigned       since_rise = 0;
    bit                have_rise = 1'b0;
    bit                last_pg = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            // R9
            check(ee_oe_n == 1'b1, "R9 oe high", ee_oe_n, 1);
            // R10
            check(ee_ce_n == !ee_data_oe, "R10 ce vs drive", ee_ce_n, !ee_data_oe);
            if (busy) check(!req_ready, "R2 ready low while busy", req_ready, 0);
            if (prev_done) begin
                check(!done, "R8 done one cycle", done, 0);
                check(req_ready, "R8 ready after done", req_ready, 1);
            end
            if (!ee_we_n) begin
                if (prev_we) begin
                    if (have_rise) begin
                        if (last_pg)
                            check(high_cnt >= WE_HIGH + PROG, "R7 programming gap", high_cnt, WE_HIGH + PROG);
                        else
                            check(high_cnt == WE_HIGH + 2, "R6 in-page gap", high_cnt, WE_HIGH + 2);
                    end
                    check(!ee_ce_n, "R4 ce low at fall", ee_ce_n, 0);
                    check(!prev_ce && prev_addr == ee_addr && prev_data == ee_data,
                          "R5 setup before fall", int'(prev_addr), int'(ee_addr));
                    cap_addr = ee_addr;
                    cap_data = ee_data;
                    low_cnt  = 1;
                end else begin
                    low_cnt++;
                    check(ee_addr == cap_addr && ee_data == cap_data && !ee_ce_n,
                          "R4 bus stable in pulse", int'(ee_addr), int'(cap_addr));
                end
            end else if (!prev_we) begin
                logic [ADDR_W+8:0] it;
                check(low_cnt == WE_LOW, "R4 pulse width", low_cnt, WE_LOW);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected write", int'(cap_addr), -1);
                    last_pg = 1'b1;
                end else begin
                    it = exp_q.pop_front();
                    check(cap_addr == it[ADDR_W+7:8], "R3 address", int'(cap_addr), int'(it[ADDR_W+7:8]));
                    check(cap_data == it[7:0], "R3 data", int'(cap_data), int'(it[7:0]));
                    last_pg = it[ADDR_W+8];
                end
                have_rise  = 1'b1;
                high_cnt   = 1;
                since_rise = 1;
            end else begin
                high_cnt++;
                since_rise++;
                if (have_rise && high_cnt == WE_HIGH)
                    check(ee_addr == cap_addr && !ee_ce_n, "R5 hold after rise", int'(ee_addr), int'(cap_addr));
            end
            if (done) begin
                check(since_rise == WE_HIGH + PROG + 1, "R8 done timing", since_rise, WE_HIGH + PROG + 1);
                check(exp_q.size() == 0, "R8 all bytes written", exp_q.size(), 0);
                busy = 1'b0;
                done_cnt++;
            end
            prev_we   = ee_we_n;
            prev_ce   = ee_ce_n;
            prev_addr = ee_addr;
            prev_data = ee_data;
            prev_done = done;
        end
    end

    task automatic finish_run;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int unsigned edges;
        bit          we_seen_low;
        repeat (3) @(negedge clk);
        // R1 / R10 reset state
        check(!req_ready && !done && ee_ce_n && ee_we_n, "R1 reset outputs", req_ready, 0);
        rst_n = 1'b1;
        edges = 0;
        we_seen_low = 1'b0;
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (!ee_we_n) we_seen_low = 1'b1;
        end while (!req_ready && edges < 1000);
        // R1 inhibit length
        check(edges == INHIB, "R1 inhibit edges", edges, INHIB);
        check(!we_seen_low, "R1 no write during inhibit", we_seen_low, 0);

        run_req(13'h100, 1);   // single byte
        run_req(13'h010, 4);   // inside one page
        run_req(13'h006, 5);   // crosses a page boundary
        run_req(13'h00F, 1);   // starts on the last address of a page
        run_req(13'h03C, 12);  // partial page, full page
        run_req(13'h1FF, 3);   // crosses a page boundary from its last byte
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule